// File: doc/BRIEF.md
# Register-Indexed Stride Value Predictor

This block predicts the next value a logical register will receive, keyed only by the register number rather than by the address of the producing instruction. Each logical register owns one history entry. An entry holds the last value written, the two most recent strides, a valid flag, a warm-up phase counter and a two-bit saturating confidence counter.

A decode stage presents a destination register number on the lookup port. In the same cycle the block returns a predicted value and a hit flag. A prediction is issued only when two conditions hold. The two stored strides must agree, and the confidence counter must be in one of its upper two states. When the real result is known, write-back presents the register number and value on the update port. On the next clock edge the entry advances through its warm-up, shifts its strides, and trains its confidence against the candidate it would have offered.

The register count is a parameter (32 by default) and the data width is 32 bits. Choosing among several predictors and replaying wrongly speculated work are handled elsewhere.

Top module: `reg_stride_vpred`

## Requirements
- R1: While reset is asserted and directly after it, every register number looks up with `lkp_hit_o` = 0 and `lkp_val_o` = 0.
- R2: The first write to an entry records the value and clears confidence to 0. It yields no prediction.
- R3: Each later write does three things. It stores (new value − last value) as the newest stride. It moves the previous newest stride into the older stride. It replaces the last value. After the second and third writes there is still no prediction.
- R4: A candidate of last value + newest stride exists only after three or more writes and only when both strides are equal. A hit needs a candidate and confidence 2 or 3. `lkp_val_o` carries the candidate on a hit and 0 otherwise.
- R5: A write to an entry that has a candidate raises confidence by 1 if the written value equals the candidate and lowers it by 1 otherwise. Confidence saturates at 0 and at 3. For a constant-stride sequence, the first hit appears after the fifth write.
- R6: A write to an entry whose strides differ leaves confidence unchanged, and such an entry gives no hit.
- R7: The lookup is combinational from stored state. A write takes effect at the clock edge. A lookup in the same cycle as a write to the same register returns the state from before that write.
- R8: A write to one register never changes the lookup result of another register.
- R9: Stride and candidate arithmetic wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_reg_i | input | 5 | Register number to predict |
| lkp_val_o | output | 32 | Predicted value, 0 without a hit |
| lkp_hit_o | output | 1 | Prediction valid |
| upd_en_i | input | 1 | Write-back strobe |
| upd_reg_i | input | 5 | Register number being written |
| upd_val_i | input | 32 | Value being written |

## Verification
A wrong warm-up phase or a wrong stride in an entry shows up at the ports in one of two ways. Either a hit appears before the fifth write of a regular sequence, or the predicted value is off by the stride error. Both are visible at the first lookup of that register after the faulty write. A confidence counter that wraps instead of saturating changes when the first hit appears after a disturbed sequence. The bench exposes this within two or three writes by probing after each write. Errors in writing the wrong entry or in same-cycle ordering show up as a hit or value change on an untouched register, or as a lookup that already reflects the write in its own cycle.

// File: rtl/vpred_pkg.sv
package vpred_pkg;
  // warm-up progress of one entry; saturates at PH_STEADY
  typedef enum logic [1:0] {
    PH_EMPTY  = 2'd0,
    PH_ONE    = 2'd1,
    PH_TWO    = 2'd2,
    PH_STEADY = 2'd3
  } vp_phase_e;
endpackage

// File: rtl/vpred_conf.sv
module vpred_conf #(
  parameter int CONF_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [CONF_W-1:0] conf_o,
  output logic              pred_o
);
  localparam logic [CONF_W-1:0] CMax = {CONF_W{1'b1}};
  localparam logic [CONF_W-1:0] CTh  = CONF_W'(1) << (CONF_W - 1);

  logic [CONF_W-1:0] conf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    conf_q <= '0;
    else if (clr_i)                 conf_q <= '0;
    else if (inc_i && conf_q != CMax) conf_q <= conf_q + 1'b1;
    else if (dec_i && conf_q != '0)   conf_q <= conf_q - 1'b1;
  end

  assign conf_o = conf_q;
  assign pred_o = (conf_q >= CTh);

  a_r5_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && conf_q != CMax) |=> conf_q == $past(conf_q) + 1'b1);
  a_r5_dec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && dec_i && conf_q != '0) |=> conf_q == $past(conf_q) - 1'b1);
  a_r5_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && conf_q == CMax) |=> conf_q == CMax);
  a_r5_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && dec_i && conf_q == '0) |=> conf_q == '0);
endmodule

// File: rtl/vpred_entry.sv
module vpred_entry
  import vpred_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CONF_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_val_i,
  output logic [DATA_W-1:0] pred_val_o,
  output logic              pred_ok_o
);
  logic              valid_q;
  vp_phase_e         phase_q;
  logic [DATA_W-1:0] last_q, str1_q, str2_q;
  logic [DATA_W-1:0] cand, new_str;
  logic              cand_ok, train, match, conf_pred;
  logic [CONF_W-1:0] conf;

  assign new_str = wr_val_i - last_q;
  assign cand    = last_q + str1_q;
  assign cand_ok = valid_q && (phase_q == PH_STEADY) && (str1_q == str2_q);
  assign train   = wr_i && cand_ok;
  assign match   = (wr_val_i == cand);

  vpred_conf #(.CONF_W(CONF_W)) u_conf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_i && !valid_q),
    .inc_i  (train && match),
    .dec_i  (train && !match),
    .conf_o (conf),
    .pred_o (conf_pred)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      phase_q <= PH_EMPTY;
      last_q  <= '0;
      str1_q  <= '0;
      str2_q  <= '0;
    end else if (wr_i) begin
      last_q <= wr_val_i;
      if (!valid_q) begin
        valid_q <= 1'b1;
        phase_q <= PH_ONE;
        str1_q  <= '0;
        str2_q  <= '0;
      end else begin
        str1_q  <= new_str;
        str2_q  <= str1_q;
        phase_q <= (phase_q == PH_ONE) ? PH_TWO : PH_STEADY;
      end
    end
  end

  assign pred_ok_o  = cand_ok && conf_pred;
  assign pred_val_o = pred_ok_o ? cand : '0;

  a_r2_first_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !valid_q) |=> (valid_q && !pred_ok_o && conf == '0));
  a_r3_warmup_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && valid_q && phase_q != PH_STEADY) |=> !pred_ok_o);
  a_r3_stride_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && valid_q) |=> (str2_q == $past(str1_q) && last_q == $past(wr_val_i)));
  a_r6_unequal_keeps_conf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && valid_q && str1_q != str2_q) |=> $stable(conf));
endmodule

// File: rtl/reg_stride_vpred.sv
module reg_stride_vpred #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int CONF_W   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lkp_reg_i,
  output logic [DATA_W-1:0] lkp_val_o,
  output logic              lkp_hit_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_reg_i,
  input  logic [DATA_W-1:0] upd_val_i
);
  logic [DATA_W-1:0] ent_val [NUM_REGS];
  logic              ent_ok  [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    vpred_entry #(.DATA_W(DATA_W), .CONF_W(CONF_W)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (upd_en_i && (upd_reg_i == IDX_W'(g))),
      .wr_val_i   (upd_val_i),
      .pred_val_o (ent_val[g]),
      .pred_ok_o  (ent_ok[g])
    );
  end

  always_comb begin
    lkp_val_o = '0;
    lkp_hit_o = 1'b0;
    if (int'(lkp_reg_i) < NUM_REGS) begin
      lkp_val_o = ent_val[lkp_reg_i];
      lkp_hit_o = ent_ok[lkp_reg_i];
    end
  end

  a_r1_reset_no_hit: assert property (@(posedge clk_i)
    !rst_ni |-> (!lkp_hit_o && lkp_val_o == '0));
  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> ((lkp_reg_i != $past(lkp_reg_i)) ||
                   (lkp_hit_o == $past(lkp_hit_o) && lkp_val_o == $past(lkp_val_o))));
  a_r8_other_reg_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_reg_i != lkp_reg_i) |=> ((lkp_reg_i != $past(lkp_reg_i)) ||
                   (lkp_hit_o == $past(lkp_hit_o) && lkp_val_o == $past(lkp_val_o))));
endmodule

// File: tb/reg_stride_vpred_bench.sv
module reg_stride_vpred_bench;
  localparam int NR = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [4:0]  lkp_reg = '0;
  logic [31:0] lkp_val;
  logic        lkp_hit;
  logic        upd_en = 1'b0;
  logic [4:0]  upd_reg = '0;
  logic [31:0] upd_val = '0;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic        s_hit;
  logic [31:0] s_val;

  // behavioural reference state
  bit          m_valid [NR];
  int          m_ph    [NR];
  int          m_conf  [NR];
  logic [31:0] m_last  [NR];
  logic [31:0] m_s1    [NR];
  logic [31:0] m_s2    [NR];

  always #2 clk = ~clk;

  reg_stride_vpred u_reg_stride_vpred (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .lkp_reg_i (lkp_reg),
    .lkp_val_o (lkp_val),
    .lkp_hit_o (lkp_hit),
    .upd_en_i  (upd_en),
    .upd_reg_i (upd_reg),
    .upd_val_i (upd_val)
  );

  function automatic bit m_cand(int r);
    return m_valid[r] && m_ph[r] >= 3 && m_s1[r] == m_s2[r];
  endfunction
  function automatic bit m_hit(int r);
    return m_cand(r) && m_conf[r] >= 2;
  endfunction
  function automatic logic [31:0] m_pv(int r);
    return m_hit(r) ? m_last[r] + m_s1[r] : 32'd0;
  endfunction

  task automatic m_write(int r, logic [31:0] v);
    if (!m_valid[r]) begin
      m_valid[r] = 1'b1; m_ph[r] = 1; m_conf[r] = 0;
      m_s1[r] = '0; m_s2[r] = '0; m_last[r] = v;
    end else begin
      if (m_cand(r)) begin
        if (v == m_last[r] + m_s1[r]) m_conf[r] = (m_conf[r] < 3) ? m_conf[r] + 1 : 3;
        else                          m_conf[r] = (m_conf[r] > 0) ? m_conf[r] - 1 : 0;
      end
      m_s2[r] = m_s1[r];
      m_s1[r] = v - m_last[r];
      m_last[r] = v;
      m_ph[r] = (m_ph[r] < 3) ? m_ph[r] + 1 : 3;
    end
  endtask

  task automatic cmp(string tag, logic gh, logic eh, logic [31:0] gv, logic [31:0] ev);
    n_vec++;
    if (gh !== eh || gv !== ev) begin
      n_bad++;
      $display("FAIL %s: hit=%0b val=%h expected hit=%0b val=%h", tag, gh, gv, eh, ev);
    end
  endtask

  // one cycle: drive at negedge, compare against model, model updates after the edge
  task automatic step(bit en, int ur, logic [31:0] uv, int lr, string tag);
    @(negedge clk);
    upd_en = en; upd_reg = 5'(ur); upd_val = uv; lkp_reg = 5'(lr);
    #1;
    s_hit = lkp_hit; s_val = lkp_val;
    cmp(tag, s_hit, m_hit(lr), s_val, m_pv(lr));
    @(posedge clk);
    if (en) m_write(ur, uv);
  endtask

  task automatic wr(int r, logic [31:0] v, string tag);
    step(1'b1, r, v, r, tag);
  endtask

  // idle lookup with an explicit expectation in addition to the model
  task automatic probe(int r, logic eh, logic [31:0] ev, string tag);
    step(1'b0, 0, 32'd0, r, tag);
    cmp(tag, s_hit, eh, s_val, ev);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_valid[i] = 0; m_ph[i] = 0; m_conf[i] = 0;
      m_last[i] = '0; m_s1[i] = '0; m_s2[i] = '0;
    end
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 during reset", lkp_hit, 1'b0, lkp_val, 32'd0);
    rst_ni = 1'b1;
    for (int r = 0; r < NR; r++) probe(r, 1'b0, 32'd0, "R1 after reset");

    // constant stride 10 on reg 3
    wr(3, 32'd100, "R2"); probe(3, 1'b0, 32'd0, "R2 first write no hit");
    wr(3, 32'd110, "R3"); probe(3, 1'b0, 32'd0, "R3 second write no hit");
    wr(3, 32'd120, "R3"); probe(3, 1'b0, 32'd0, "R3 third write no hit");
    wr(3, 32'd130, "R5"); probe(3, 1'b0, 32'd0, "R5 conf 1 no hit");
    wr(3, 32'd140, "R5"); probe(3, 1'b1, 32'd150, "R5 first hit after fifth write");
    probe(4, 1'b0, 32'd0, "R8 neighbour untouched");

    // same-cycle write and lookup on reg 3 sees old state
    step(1'b1, 3, 32'd150, 3, "R7 same cycle");
    cmp("R7 same cycle old state", s_hit, 1'b1, s_val, 32'd150);
    probe(3, 1'b1, 32'd160, "R7 visible next cycle");

    // disturb: conf 3 -> 2, strides unequal, then realign
    wr(3, 32'd999, "R6"); probe(3, 1'b0, 32'd0, "R6 unequal strides no hit");
    wr(3, 32'd1848, "R6"); probe(3, 1'b1, 32'd2697, "R6 conf kept while unequal");

    // upper saturation on reg 12
    for (int k = 0; k < 10; k++) wr(12, 32'(3 * k), "R5 climb");
    wr(12, 32'd100, "R5"); wr(12, 32'd173, "R5");
    probe(12, 1'b1, 32'd246, "R5 saturate high");

    // lower saturation on reg 20
    wr(20, 32'd5, "R5"); wr(20, 32'd5, "R5"); wr(20, 32'd5, "R5");
    wr(20, 32'd6, "R5"); wr(20, 32'd7, "R5");
    probe(20, 1'b0, 32'd0, "R5 saturate low");
    wr(20, 32'd8, "R5"); probe(20, 1'b0, 32'd0, "R5 conf 1 after floor");
    wr(20, 32'd9, "R5"); probe(20, 1'b1, 32'd10, "R5 conf 2 after floor");

    // wrap-around on reg 31
    wr(31, 32'hFFFF_FFE0, "R9"); wr(31, 32'hFFFF_FFF0, "R9");
    wr(31, 32'h0000_0000, "R9"); wr(31, 32'h0000_0010, "R9");
    wr(31, 32'h0000_0020, "R9");
    probe(31, 1'b1, 32'h0000_0030, "R9 wrap up");
    wr(30, 32'd5, "R9"); wr(30, 32'd2, "R9"); wr(30, 32'hFFFF_FFFF, "R9");
    wr(30, 32'hFFFF_FFFC, "R9"); wr(30, 32'hFFFF_FFF9, "R9");
    probe(30, 1'b1, 32'hFFFF_FFF6, "R9 negative stride");
    probe(29, 1'b0, 32'd0, "R8 untouched entry");

    // mixed traffic against the model
    begin
      logic [31:0] g_last [8];
      logic [31:0] g_str  [8];
      for (int i = 0; i < 8; i++) begin g_last[i] = $urandom; g_str[i] = $urandom_range(0, 40); end
      for (int c = 0; c < 4000; c++) begin
        int r  = $urandom_range(0, 7);
        int lr = ($urandom_range(0, 1) == 0) ? r : $urandom_range(0, NR - 1);
        bit en = ($urandom_range(0, 3) != 0);
        logic [31:0] v;
        if ($urandom_range(0, 15) == 0) g_str[r] = $urandom_range(0, 40);
        v = ($urandom_range(0, 9) == 0) ? $urandom : g_last[r] + g_str[r];
        if (en) g_last[r] = v;
        step(en, r, v, lr, "R4 mixed");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule